// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the timing enables a UART needs from a fast reference clock. It has two channels, one for transmit and one for receive. Each channel has its own divisor and runs at its own rate, so the two directions can use unrelated baud rates at the same time. A divisor has a 16-bit whole part and a 4-bit sixteenths part. A mode field chooses 16, 8 or 4 sample ticks per serial bit. One shared input divides the reference by 1 or by 4 before either divisor sees it.

Each channel drives two outputs. The sample tick is a one-cycle enable that marks the end of every oversampling period. The bit tick is an enable that rises together with the sample tick that closes each serial bit. The fraction is realised with a 4-bit phase accumulator. Each sample period lasts either N or N+1 prescaled clocks, and the extra clocks are spread out so that every 16 periods add up to exactly 16N+F. Software loads the divisors through a byte-wide write port. A new setting takes effect only when the current sample period ends, so a period that is already running keeps its length.

Top module: `uart_frac_baudgen`

## Requirements
- R1: When `div4_sel` is 1, the prescaled enable occurs once every 4 reference cycles, and every sample period is 4 times as long as it is when `div4_sel` is 0.
- R2: A write with `wr_en` high stores `wr_data` into the register selected by `wr_addr`. Bit 2 of the address picks the channel: 0 is transmit, 1 is receive. Bits 1:0 pick the register: 0 is the low byte of the whole divisor, 1 is its high byte, and 2 is the config byte, which holds the fraction in bits 3:0 and the mode in bits 5:4. Writes with bits 1:0 equal to 3 have no effect.
- R3: While `rst_n` is low, all four tick outputs are low. After reset, both channels use whole part 1, fraction 0 and mode 16x. With `div4_sel` at 0, the sample ticks start within 8 cycles of reset release.
- R4: A sample period lasts N prescaled clocks, plus one more when the accumulator plus the fraction F reaches 16 or more. The accumulator then keeps the sum modulo 16, and it starts at 0 after reset. As a result, any 16 consecutive periods total exactly (16N+F) times the prescale ratio.
- R5: Mode values give these ratios: 00 is 16x, 01 is 8x, 10 is 4x, and 11 behaves as 16x. The bit tick is high only together with a sample tick, on every 16th, 8th or 4th sample tick. A count that exceeds a smaller newly chosen ratio fires at the next sample tick.
- R6: A whole part of 0 behaves as 1.
- R7: A write changes the length of a sample period only from the next period boundary of that channel. The period that is running when the write arrives keeps its length, and no period is ever shorter than the divisor that governs it.
- R8: The transmit and receive channels keep separate registers, accumulators and counters. A write to one channel never changes the timing of the other.
- R9: Each tick is a one-cycle synchronous enable. When the prescale ratio is 4, a sample tick is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| div4_sel | input | 1 | Shared prescale select: 0 divides by 1, 1 divides by 4 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Bit 2 selects the channel, bits 1:0 select the register |
| wr_data | input | 8 | Write data |
| tx_sample_tick | output | 1 | Transmit oversampling enable |
| tx_bit_tick | output | 1 | Transmit bit-period enable |
| rx_sample_tick | output | 1 | Receive oversampling enable |
| rx_bit_tick | output | 1 | Receive bit-period enable |

## Verification
Suppose a sample tick is seen in cycle c. A write presented in that same cycle is captured at the edge that reloads the period counter, so it misses that reload. The next tick is therefore due in cycle c + L×P, where L is the period chosen from the settings held before cycle c and P is 1 or 4. The bench keeps this arithmetic for each channel. It handles each cycle in a fixed order: it compares both ticks, advances its model, and only then applies that cycle's write. It compares every cycle on the falling edge. Reset release has an internal synchroniser and prescaler phase, so each channel's model is anchored on its first observed tick, and every later tick must match the predicted cycle exactly. After each configuration, windows of 16 periods are compared with (16N+F)×P.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

  localparam int BG_INT_W  = 16;
  localparam int BG_FRAC_W = 4;
  localparam int BG_CHANS  = 2;

  typedef enum logic [1:0] {
    OS_X16 = 2'b00,
    OS_X8  = 2'b01,
    OS_X4  = 2'b10,
    OS_RSV = 2'b11
  } os_mode_e;

  // index of the last sample tick of a bit for each mode
  function automatic logic [3:0] os_last(input os_mode_e m);
    case (m)
      OS_X8:   os_last = 4'd7;
      OS_X4:   os_last = 4'd3;
      default: os_last = 4'd15;
    endcase
  endfunction

endpackage

// File: rtl/baudgen_rst_sync.sv
module baudgen_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/baudgen_presc.sv
module baudgen_presc (
  input  logic clk,
  input  logic rst_n,
  input  logic div4_sel,
  output logic div4_q,
  output logic pre_en
);

  logic [1:0] cnt_q, cnt_d;
  logic       sel_q;
  logic       en_q, en_d;

  always_comb begin
    cnt_d = sel_q ? cnt_q + 2'd1 : 2'd0;
    en_d  = !sel_q || (cnt_q == 2'd3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 2'd0;
      sel_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= div4_sel;
      en_q  <= en_d;
    end
  end

  assign pre_en = en_q;
  assign div4_q = sel_q;

endmodule

// File: rtl/baudgen_chan.sv
module baudgen_chan
  import baudgen_pkg::*;
#(
  parameter int INT_W  = BG_INT_W,
  parameter int FRAC_W = BG_FRAC_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pre_en,
  input  logic       wr_en,
  input  logic [1:0] wr_reg,
  input  logic [7:0] wr_data,
  output logic       sample_tick,
  output logic       bit_tick
);

  localparam int HI_W = INT_W - 8;

  // programmed settings
  logic [INT_W-1:0]  int_q, int_d;
  logic [FRAC_W-1:0] frac_q, frac_d;
  os_mode_e          mode_q, mode_d;

  // running state
  logic [INT_W-1:0]  rem_q, rem_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  os_mode_e          act_q, act_d;
  logic [3:0]        bcnt_q, bcnt_d;

  logic [INT_W-1:0]  n_eff;
  logic [FRAC_W:0]   acc_sum;
  logic              boundary;
  logic              bit_hit;

  always_comb begin
    int_d  = int_q;
    frac_d = frac_q;
    mode_d = mode_q;
    if (wr_en) begin
      case (wr_reg)
        2'd0:    int_d[7:0]       = wr_data;
        2'd1:    int_d[INT_W-1:8] = wr_data[HI_W-1:0];
        2'd2: begin
          frac_d = wr_data[FRAC_W-1:0];
          mode_d = os_mode_e'(wr_data[5:4]);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    n_eff    = (int_q == '0) ? INT_W'(1) : int_q;
    acc_sum  = {1'b0, acc_q} + {1'b0, frac_q};
    boundary = pre_en && (rem_q == '0);
    bit_hit  = boundary && (bcnt_q >= os_last(act_q));
    rem_d    = rem_q;
    acc_d    = acc_q;
    act_d    = act_q;
    bcnt_d   = bcnt_q;
    if (pre_en) begin
      if (rem_q == '0) begin
        rem_d  = n_eff - INT_W'(1) + INT_W'(acc_sum[FRAC_W]);
        acc_d  = acc_sum[FRAC_W-1:0];
        act_d  = mode_q;
        bcnt_d = bit_hit ? 4'd0 : bcnt_q + 4'd1;
      end else begin
        rem_d  = rem_q - INT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= INT_W'(1);
      frac_q <= '0;
      mode_q <= OS_X16;
      rem_q  <= '0;
      acc_q  <= '0;
      act_q  <= OS_X16;
      bcnt_q <= 4'd0;
    end else begin
      int_q  <= int_d;
      frac_q <= frac_d;
      mode_q <= mode_d;
      rem_q  <= rem_d;
      acc_q  <= acc_d;
      act_q  <= act_d;
      bcnt_q <= bcnt_d;
    end
  end

  assign sample_tick = boundary;
  assign bit_tick    = bit_hit;

endmodule

// File: rtl/uart_frac_baudgen.sv
module uart_frac_baudgen
  import baudgen_pkg::*;
#(
  parameter int INT_W  = BG_INT_W,
  parameter int FRAC_W = BG_FRAC_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       div4_sel,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       tx_sample_tick,
  output logic       tx_bit_tick,
  output logic       rx_sample_tick,
  output logic       rx_bit_tick
);

  logic                rst_sync_n;
  logic                presc_div4_q;
  logic                pre_en;
  logic [BG_CHANS-1:0] s_tick;
  logic [BG_CHANS-1:0] b_tick;

  baudgen_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  baudgen_presc u_presc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .div4_sel (div4_sel),
    .div4_q   (presc_div4_q),
    .pre_en   (pre_en)
  );

  for (genvar gi = 0; gi < BG_CHANS; gi++) begin : g_chan
    logic ch_wr;
    assign ch_wr = wr_en && (wr_addr[2] == 1'(gi)) && (wr_addr[1:0] != 2'd3);

    baudgen_chan #(
      .INT_W  (INT_W),
      .FRAC_W (FRAC_W)
    ) u_chan (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .pre_en      (pre_en),
      .wr_en       (ch_wr),
      .wr_reg      (wr_addr[1:0]),
      .wr_data     (wr_data),
      .sample_tick (s_tick[gi]),
      .bit_tick    (b_tick[gi])
    );
  end

  assign tx_sample_tick = s_tick[0];
  assign tx_bit_tick    = b_tick[0];
  assign rx_sample_tick = s_tick[1];
  assign rx_bit_tick    = b_tick[1];

endmodule

// File: rtl/uart_frac_baudgen_chk.sv
module uart_frac_baudgen_chk (
  input logic clk,
  input logic rst_n,
  input logic rst_int_n,
  input logic div4_q,
  input logic pre_en,
  input logic tx_s,
  input logic tx_b,
  input logic rx_s,
  input logic rx_b
);

  // R3: no enables while reset is applied
  a_r3_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (!tx_s && !rx_s && !tx_b && !rx_b));

  // R5: bit enable only together with a sample enable
  a_r5_tx_bit_on_sample: assert property (@(posedge clk) disable iff (!rst_int_n)
    tx_b |-> tx_s);
  a_r5_rx_bit_on_sample: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_b |-> rx_s);

  // R1: divide-by-4 leaves a gap after each prescaled enable
  a_r1_presc_gap: assert property (@(posedge clk) disable iff (!rst_int_n)
    (div4_q && pre_en) |=> !pre_en);

  // R9: single-cycle sample enables under divide-by-4
  a_r9_tx_single: assert property (@(posedge clk) disable iff (!rst_int_n)
    (div4_q && tx_s) |=> !tx_s);
  a_r9_rx_single: assert property (@(posedge clk) disable iff (!rst_int_n)
    (div4_q && rx_s) |=> !rx_s);

endmodule

bind uart_frac_baudgen uart_frac_baudgen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_int_n (rst_sync_n),
  .div4_q    (presc_div4_q),
  .pre_en    (pre_en),
  .tx_s      (tx_sample_tick),
  .tx_b      (tx_bit_tick),
  .rx_s      (rx_sample_tick),
  .rx_b      (rx_bit_tick)
);

// File: tb/tb_uart_frac_baudgen.sv
module tb_uart_frac_baudgen;

  logic       clk;
  logic       rst_n;
  logic       div4_sel;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic       tx_sample_tick, tx_bit_tick, rx_sample_tick, rx_bit_tick;

  uart_frac_baudgen dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .div4_sel       (div4_sel),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .tx_sample_tick (tx_sample_tick),
    .tx_bit_tick    (tx_bit_tick),
    .rx_sample_tick (rx_sample_tick),
    .rx_bit_tick    (rx_bit_tick)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int     n_chk = 0;
  int     n_err = 0;
  bit     done  = 0;
  longint cyc   = 0;
  int     presc = 1;
  string  tag_s = "R4";

  // behavioural model, index 0 = transmit, 1 = receive
  int     m_n[2], m_f[2], m_m[2], m_acc[2], m_bcnt[2], m_ratio[2];
  longint m_nxt[2];
  bit     m_anch[2];
  longint tq0[$], tq1[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int ratio_of(input int m);
    return (m == 1) ? 8 : (m == 2) ? 4 : 16;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_n[c] = 1; m_f[c] = 0; m_m[c] = 0; m_acc[c] = 0;
      m_bcnt[c] = 0; m_ratio[c] = 16; m_nxt[c] = 0; m_anch[c] = 0;
    end
    tq0.delete(); tq1.delete();
  endtask

  task automatic model_cycle();
    for (int c = 0; c < 2; c++) begin
      bit s, b, bound, eb;
      int n, carry;
      s = (c == 0) ? tx_sample_tick : rx_sample_tick;
      b = (c == 0) ? tx_bit_tick : rx_bit_tick;
      if (!m_anch[c]) begin
        bound = s;
        if (s) m_anch[c] = 1;
      end else begin
        bound = (cyc == m_nxt[c]);
      end
      if (m_anch[c]) begin
        eb = bound && (m_bcnt[c] >= m_ratio[c] - 1);
        chk(s == bound, tag_s, (c == 0) ? "tx sample tick" : "rx sample tick", s, bound);
        chk(b == eb, "R5", (c == 0) ? "tx bit tick" : "rx bit tick", b, eb);
        if (bound) begin
          m_bcnt[c]  = eb ? 0 : m_bcnt[c] + 1;
          m_ratio[c] = ratio_of(m_m[c]);
          n          = (m_n[c] == 0) ? 1 : m_n[c];
          carry      = (m_acc[c] + m_f[c] >= 16) ? 1 : 0;
          m_acc[c]   = (m_acc[c] + m_f[c]) % 16;
          m_nxt[c]   = cyc + longint'((n + carry) * presc);
          if (c == 0) tq0.push_back(cyc); else tq1.push_back(cyc);
        end
      end
    end
  endtask

  task automatic model_write(input logic [2:0] a, input logic [7:0] d);
    int c;
    c = a[2];
    case (a[1:0])
      2'd0: m_n[c] = (m_n[c] & 32'hFF00) | int'(d);
      2'd1: m_n[c] = (m_n[c] & 32'h00FF) | (int'(d) << 8);
      2'd2: begin m_f[c] = int'(d) & 15; m_m[c] = (int'(d) >> 4) & 3; end
      default: ;
    endcase
  endtask

  task automatic step(input logic we, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cyc++;
    model_cycle();
    wr_en = we; wr_addr = a; wr_data = d;
    if (we) model_write(a, d);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(1'b0, 3'd0, 8'd0);
  endtask

  task automatic do_reset(input int p);
    int waited;
    rst_n = 1'b0; presc = p; div4_sel = (p == 4); wr_en = 1'b0;
    wr_addr = 3'd0; wr_data = 8'd0;
    model_reset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cyc++;
      chk(!tx_sample_tick && !rx_sample_tick && !tx_bit_tick && !rx_bit_tick,
          "R3", "ticks during reset",
          {tx_sample_tick, rx_sample_tick, tx_bit_tick, rx_bit_tick}, 0);
    end
    rst_n = 1'b1;
    waited = 0;
    while (!(m_anch[0] && m_anch[1]) && waited < 40) begin
      step(1'b0, 3'd0, 8'd0);
      waited++;
    end
    if (p == 1) chk(waited <= 8, "R3", "cycles to first tick after release", waited, 8);
  endtask

  task automatic config_ch(input int c, input int n, input int f, input int m);
    step(1'b1, 3'(c * 4 + 0), 8'(n & 255));
    step(1'b1, 3'(c * 4 + 1), 8'((n >> 8) & 255));
    step(1'b1, 3'(c * 4 + 2), 8'((m << 4) | f));
  endtask

  // windows of 16 periods against (16N+F)*P
  task automatic window_chk(input int c, input int n, input int f, input string req);
    longint t[$];
    int ne;
    t  = (c == 0) ? tq0 : tq1;
    ne = (n == 0) ? 1 : n;
    chk(t.size() >= 17, req, "periods observed", t.size(), 17);
    if (t.size() >= 17) begin
      chk(t[16] - t[0] == longint'((16 * ne + f) * presc), req, "first 16-period window",
          t[16] - t[0], (16 * ne + f) * presc);
      chk(t[t.size()-1] - t[t.size()-17] == longint'((16 * ne + f) * presc), req,
          "last 16-period window", t[t.size()-1] - t[t.size()-17], (16 * ne + f) * presc);
    end
  endtask

  task automatic run_pair(input int p, input int tn, input int tf, input int tm,
                          input int rn, input int rf, input int rm,
                          input int len, input string req);
    do_reset(p);
    tag_s = req;
    config_ch(0, tn, tf, tm);
    config_ch(1, rn, rf, rm);
    tq0.delete(); tq1.delete();
    idle(len);
    window_chk(0, tn, tf, req);
    window_chk(1, rn, rf, req);
  endtask

  initial begin
    // R3 + R4 with the reset divisor, then fractional 16x/8x at prescale 1
    run_pair(1, 5, 3, 0, 7, 0, 1, 800, "R4,R5");
    // R1 + R9: prescale 4, 4x with fraction 15, 8x with an odd fraction
    run_pair(4, 3, 15, 2, 2, 9, 1, 1200, "R1,R9");
    // R6: whole part 0, reserved mode 11; R8: slow receive channel with high byte set
    run_pair(1, 0, 0, 3, 258, 1, 2, 4600, "R6,R8");
    // R7 + R2: mid-period rewrite, ignored address slot
    do_reset(1);
    tag_s = "R7";
    config_ch(0, 40, 0, 0);
    config_ch(1, 6, 5, 2);
    idle(100);
    step(1'b1, 3'd0, 8'd3);    // R7: tx shortens, running period keeps its length
    step(1'b1, 3'd3, 8'hFF);   // R2: slot 3 ignored
    step(1'b1, 3'd7, 8'h00);   // R2: slot 7 ignored
    step(1'b1, 3'd6, 8'h12);   // R8: rx becomes F=2, 8x; tx unaffected
    tq0.delete(); tq1.delete();
    idle(400);
    window_chk(0, 3, 0, "R2,R7");
    window_chk(1, 6, 2, "R8");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule